// File: doc/BRIEF.md
# NAND Command and Address Cycle Sequencer

This block sits on the host side of a NAND flash bus and turns one operation request into the command and address cycles that the device latches. A request names the opening command byte, a column address, a row address, flags for which of the two address types take part, and a selector for an optional closing command. The engine then drives the chip enable, the command latch strobe, the address latch strobe, the write strobe and the eight-bit data lane on its own until the last byte has been latched.

The device captures every byte on the rising edge of the write strobe. The engine therefore holds the data lane and both latch strobes steady from the falling edge of the write strobe until one clock after its rising edge. The lengths of the strobe low and high phases are counts of clock cycles that come with each request. Address bytes go out least significant first. Unused high bits are forced to zero. Column bit 0 is cleared when the interface runs in double data rate mode. An erase-type request leaves out the column cycles entirely. Data transfer, error correction and busy polling belong to other blocks.

Top module: `nand_cmd_seq`

## Requirements
- R1: `req_ready` is high only while the engine is idle, which is also the only time `nand_ce_n` is high. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A request presented while the engine is busy is held off and is taken only after the running operation ends.
- R2: The first bus cycle of every operation carries `req_cmd` with CLE high and ALE low.
- R3: When `req_has_col` is 1, COL_CYCLES address cycles (ALE high, CLE low) follow the command, least significant byte first. Column bits at and above COL_BITS (default 15) are sent as zero.
- R4: With `ddr_mode` = 1, column bit 0 is sent as zero. With `ddr_mode` = 0, it is sent as given.
- R5: When `req_has_row` is 1, ROW_CYCLES address cycles follow any column cycles, least significant byte first. Row bits at and above ROW_BITS (default 21) are sent as zero.
- R6: With `req_has_col` = 0, no column cycle is sent, which suits block erase. With `req_has_row` = 0, no row cycle is sent.
- R7: `req_confirm_sel` chooses the closing command cycle (CLE high), sent after all address cycles: 0 sends none, 1 sends `req_confirm`, 2 sends 2Dh (first half-page read) and 3 sends 2Eh (second half-page read).
- R8: In every bus cycle `nand_we_n` stays low for max(`we_low_clks`,1) clocks, then high for max(`we_high_clks`,1) clocks. CLE, ALE and DQ do not change at the rising edge of the strobe or on the clock that follows it. The strobe is never low while `nand_ce_n` is high.
- R9: Between two bus cycles, and after the last one, there is exactly one clock with CLE and ALE both low and `nand_we_n` high. CLE and ALE are never high together.
- R10: `op_done` pulses for one clock, in the gap clock after the high phase of the final cycle. On the next clock the engine is idle, with `nand_ce_n` high and `req_ready` high.
- R11: Reset leaves `nand_ce_n` and `nand_we_n` high, CLE, ALE and `op_done` low, and `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_cmd | input | 8 | Opening command byte |
| req_col | input | 8*COL_CYCLES | Column address |
| req_row | input | 8*ROW_CYCLES | Row address |
| req_has_col | input | 1 | Send column cycles |
| req_has_row | input | 1 | Send row cycles |
| req_confirm_sel | input | 2 | Closing command choice: 0 none, 1 given byte, 2 = 2Dh, 3 = 2Eh |
| req_confirm | input | 8 | Closing byte used when the choice is 1 |
| ddr_mode | input | 1 | Interface in double data rate mode |
| we_low_clks | input | TIME_W | Strobe low phase length in clocks |
| we_high_clks | input | TIME_W | Strobe high phase length in clocks |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_dq | output | 8 | Data lane |
| op_done | output | 1 | Last cycle latched |

## Verification
The properties assume that the request fields only matter on the edge where the request is taken. They also assume that the host keeps `req_valid` raised until `req_ready` lets the request in. The bench drives all inputs on the falling clock edge. It holds each request steady until it samples `req_ready` high, and it lowers `req_valid` or changes the fields only after the accepting edge. The phase counts given include zero, and the bench expects zero to act as one clock. The bench stacks a second request behind a busy engine to show that it waits, rather than relying on the engine to refuse it.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        CF_NONE   = 2'd0,
        CF_GIVEN  = 2'd1,
        CF_HALF_A = 2'd2,
        CF_HALF_B = 2'd3
    } confirm_e;

    localparam logic [7:0] HALF_A_CODE = 8'h2D;
    localparam logic [7:0] HALF_B_CODE = 8'h2E;

endpackage

// File: rtl/nand_addr_pack.sv
// Turns the latched request into a fixed slot list:
// slot 0 command, then column bytes, then row bytes, then the closing command.
module nand_addr_pack
    import nand_seq_pkg::*;
#(
    parameter int COL_CYCLES = 2,
    parameter int ROW_CYCLES = 3,
    parameter int COL_BITS   = 15,
    parameter int ROW_BITS   = 21,
    localparam int COL_W     = 8 * COL_CYCLES,
    localparam int ROW_W     = 8 * ROW_CYCLES,
    localparam int N_SLOTS   = 2 + COL_CYCLES + ROW_CYCLES
) (
    input  logic [7:0]                 cmd,
    input  logic [COL_W-1:0]           col,
    input  logic [ROW_W-1:0]           row,
    input  logic                       has_col,
    input  logic                       has_row,
    input  logic [1:0]                 confirm_sel,
    input  logic [7:0]                 confirm_byte,
    input  logic                       ddr,
    output logic [N_SLOTS-1:0][7:0]    slot_byte,
    output logic [N_SLOTS-1:0]         slot_is_cmd,
    output logic [N_SLOTS-1:0]         slot_en
);

    localparam int CONF_SLOT = N_SLOTS - 1;

    logic [COL_W-1:0] col_kept;
    logic [COL_W-1:0] col_eff;
    logic [ROW_W-1:0] row_kept;

    // drop unused high address bits
    for (genvar b = 0; b < COL_W; b++) begin : g_col_mask
        if (b < COL_BITS) begin : g_keep
            assign col_kept[b] = col[b];
        end else begin : g_zero
            assign col_kept[b] = 1'b0;
        end
    end

    for (genvar b = 0; b < ROW_W; b++) begin : g_row_mask
        if (b < ROW_BITS) begin : g_keep
            assign row_kept[b] = row[b];
        end else begin : g_zero
            assign row_kept[b] = 1'b0;
        end
    end

    // double data rate transfers are word aligned on the column
    assign col_eff = {col_kept[COL_W-1:1], col_kept[0] & ~ddr};

    assign slot_byte[0]   = cmd;
    assign slot_is_cmd[0] = 1'b1;
    assign slot_en[0]     = 1'b1;

    for (genvar k = 0; k < COL_CYCLES; k++) begin : g_col_slot
        assign slot_byte[1+k]   = col_eff[8*k +: 8];
        assign slot_is_cmd[1+k] = 1'b0;
        assign slot_en[1+k]     = has_col;
    end

    for (genvar k = 0; k < ROW_CYCLES; k++) begin : g_row_slot
        assign slot_byte[1+COL_CYCLES+k]   = row_kept[8*k +: 8];
        assign slot_is_cmd[1+COL_CYCLES+k] = 1'b0;
        assign slot_en[1+COL_CYCLES+k]     = has_row;
    end

    always_comb begin
        unique case (confirm_e'(confirm_sel))
            CF_GIVEN:  slot_byte[CONF_SLOT] = confirm_byte;
            CF_HALF_A: slot_byte[CONF_SLOT] = HALF_A_CODE;
            CF_HALF_B: slot_byte[CONF_SLOT] = HALF_B_CODE;
            default:   slot_byte[CONF_SLOT] = 8'h00;
        endcase
    end

    assign slot_is_cmd[CONF_SLOT] = 1'b1;
    assign slot_en[CONF_SLOT]     = (confirm_e'(confirm_sel) != CF_NONE);

endmodule

// File: rtl/nand_slot_pick.sv
// Finds the first enabled slot after the current one.
module nand_slot_pick #(
    parameter int N_SLOTS = 7,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] slot_en,
    input  logic [IDX_W-1:0]   cur_idx,
    output logic [IDX_W-1:0]   nxt_idx,
    output logic               nxt_valid
);

    always_comb begin
        nxt_idx   = cur_idx;
        nxt_valid = 1'b0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if ((i > int'(cur_idx)) && slot_en[i]) begin
                nxt_idx   = IDX_W'(i);
                nxt_valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/nand_cycle_ctrl.sv
// Phase machine: LOW (strobe low) -> HIGH (strobe high) -> GAP (strobes idle).
module nand_cycle_ctrl
    import nand_seq_pkg::*;
#(
    parameter int COL_W   = 16,
    parameter int ROW_W   = 24,
    parameter int TIME_W  = 4,
    parameter int N_SLOTS = 7,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [7:0]              req_cmd,
    input  logic [COL_W-1:0]        req_col,
    input  logic [ROW_W-1:0]        req_row,
    input  logic                    req_has_col,
    input  logic                    req_has_row,
    input  logic [1:0]              req_confirm_sel,
    input  logic [7:0]              req_confirm,
    input  logic                    ddr_mode,
    input  logic [TIME_W-1:0]       we_low_clks,
    input  logic [TIME_W-1:0]       we_high_clks,
    input  logic [N_SLOTS-1:0][7:0] slot_byte,
    input  logic [N_SLOTS-1:0]      slot_is_cmd,
    input  logic [IDX_W-1:0]        nxt_idx,
    input  logic                    nxt_valid,
    output logic [7:0]              lat_cmd,
    output logic [COL_W-1:0]        lat_col,
    output logic [ROW_W-1:0]        lat_row,
    output logic                    lat_has_col,
    output logic                    lat_has_row,
    output logic [1:0]              lat_confirm_sel,
    output logic [7:0]              lat_confirm,
    output logic                    lat_ddr,
    output logic [IDX_W-1:0]        cur_idx,
    output logic                    bus_ce_n,
    output logic                    bus_cle,
    output logic                    bus_ale,
    output logic                    bus_we_n,
    output logic [7:0]              bus_dq,
    output logic                    done
);

    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   idx;
        logic [TIME_W-1:0]  cnt;
        logic [TIME_W-1:0]  low_len;
        logic [TIME_W-1:0]  high_len;
        logic [7:0]         cmd;
        logic [COL_W-1:0]   col;
        logic [ROW_W-1:0]   row;
        logic               has_col;
        logic               has_row;
        logic [1:0]         confirm_sel;
        logic [7:0]         confirm;
        logic               ddr;
        logic               ce_n;
        logic               cle;
        logic               ale;
        logic               we_n;
        logic [7:0]         dq;
        logic               done;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        phase:       PH_IDLE,
        idx:         '0,
        cnt:         '0,
        low_len:     TIME_W'(1),
        high_len:    TIME_W'(1),
        cmd:         '0,
        col:         '0,
        row:         '0,
        has_col:     1'b0,
        has_row:     1'b0,
        confirm_sel: 2'd0,
        confirm:     '0,
        ddr:         1'b0,
        ce_n:        1'b1,
        cle:         1'b0,
        ale:         1'b0,
        we_n:        1'b1,
        dq:          '0,
        done:        1'b0
    };

    ctrl_t st_d, st_q;
    logic [TIME_W-1:0] low_req, high_req;

    // a zero phase length is treated as one clock
    assign low_req  = (we_low_clks  == '0) ? TIME_W'(1) : we_low_clks;
    assign high_req = (we_high_clks == '0) ? TIME_W'(1) : we_high_clks;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.cmd         = req_cmd;
                    st_d.col         = req_col;
                    st_d.row         = req_row;
                    st_d.has_col     = req_has_col;
                    st_d.has_row     = req_has_row;
                    st_d.confirm_sel = req_confirm_sel;
                    st_d.confirm     = req_confirm;
                    st_d.ddr         = ddr_mode;
                    st_d.low_len     = low_req;
                    st_d.high_len    = high_req;
                    st_d.idx         = '0;
                    st_d.cnt         = low_req - TIME_W'(1);
                    st_d.phase       = PH_LOW;
                    st_d.ce_n        = 1'b0;
                    st_d.cle         = 1'b1;
                    st_d.ale         = 1'b0;
                    st_d.we_n        = 1'b0;
                    st_d.dq          = req_cmd;
                end
            end
            PH_LOW: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_HIGH;
                    st_d.cnt   = st_q.high_len - TIME_W'(1);
                    st_d.we_n  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - TIME_W'(1);
                end
            end
            PH_HIGH: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_GAP;
                    st_d.cle   = 1'b0;
                    st_d.ale   = 1'b0;
                    st_d.done  = ~nxt_valid;
                end else begin
                    st_d.cnt = st_q.cnt - TIME_W'(1);
                end
            end
            PH_GAP: begin
                if (nxt_valid) begin
                    st_d.idx   = nxt_idx;
                    st_d.phase = PH_LOW;
                    st_d.cnt   = st_q.low_len - TIME_W'(1);
                    st_d.we_n  = 1'b0;
                    st_d.cle   = slot_is_cmd[nxt_idx];
                    st_d.ale   = ~slot_is_cmd[nxt_idx];
                    st_d.dq    = slot_byte[nxt_idx];
                end else begin
                    st_d.phase = PH_IDLE;
                    st_d.ce_n  = 1'b1;
                end
            end
            default: st_d = CTRL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready       = (st_q.phase == PH_IDLE);
    assign lat_cmd         = st_q.cmd;
    assign lat_col         = st_q.col;
    assign lat_row         = st_q.row;
    assign lat_has_col     = st_q.has_col;
    assign lat_has_row     = st_q.has_row;
    assign lat_confirm_sel = st_q.confirm_sel;
    assign lat_confirm     = st_q.confirm;
    assign lat_ddr         = st_q.ddr;
    assign cur_idx         = st_q.idx;
    assign bus_ce_n        = st_q.ce_n;
    assign bus_cle         = st_q.cle;
    assign bus_ale         = st_q.ale;
    assign bus_we_n        = st_q.we_n;
    assign bus_dq          = st_q.dq;
    assign done            = st_q.done;

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int COL_CYCLES = 2,
    parameter int ROW_CYCLES = 3,
    parameter int COL_BITS   = 15,
    parameter int ROW_BITS   = 21,
    parameter int TIME_W     = 4,
    localparam int COL_W     = 8 * COL_CYCLES,
    localparam int ROW_W     = 8 * ROW_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_cmd,
    input  logic [COL_W-1:0]  req_col,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              req_has_col,
    input  logic              req_has_row,
    input  logic [1:0]        req_confirm_sel,
    input  logic [7:0]        req_confirm,
    input  logic              ddr_mode,
    input  logic [TIME_W-1:0] we_low_clks,
    input  logic [TIME_W-1:0] we_high_clks,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic [7:0]        nand_dq,
    output logic              op_done
);

    localparam int N_SLOTS = 2 + COL_CYCLES + ROW_CYCLES;
    localparam int IDX_W   = $clog2(N_SLOTS);

    logic [7:0]              lat_cmd;
    logic [COL_W-1:0]        lat_col;
    logic [ROW_W-1:0]        lat_row;
    logic                    lat_has_col;
    logic                    lat_has_row;
    logic [1:0]              lat_confirm_sel;
    logic [7:0]              lat_confirm;
    logic                    lat_ddr;
    logic [N_SLOTS-1:0][7:0] slot_byte;
    logic [N_SLOTS-1:0]      slot_is_cmd;
    logic [N_SLOTS-1:0]      slot_en;
    logic [IDX_W-1:0]        cur_idx;
    logic [IDX_W-1:0]        nxt_idx;
    logic                    nxt_valid;

    nand_addr_pack #(
        .COL_CYCLES (COL_CYCLES),
        .ROW_CYCLES (ROW_CYCLES),
        .COL_BITS   (COL_BITS),
        .ROW_BITS   (ROW_BITS)
    ) pack_i (
        .cmd          (lat_cmd),
        .col          (lat_col),
        .row          (lat_row),
        .has_col      (lat_has_col),
        .has_row      (lat_has_row),
        .confirm_sel  (lat_confirm_sel),
        .confirm_byte (lat_confirm),
        .ddr          (lat_ddr),
        .slot_byte    (slot_byte),
        .slot_is_cmd  (slot_is_cmd),
        .slot_en      (slot_en)
    );

    nand_slot_pick #(
        .N_SLOTS (N_SLOTS)
    ) pick_i (
        .slot_en   (slot_en),
        .cur_idx   (cur_idx),
        .nxt_idx   (nxt_idx),
        .nxt_valid (nxt_valid)
    );

    nand_cycle_ctrl #(
        .COL_W   (COL_W),
        .ROW_W   (ROW_W),
        .TIME_W  (TIME_W),
        .N_SLOTS (N_SLOTS)
    ) ctrl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_cmd         (req_cmd),
        .req_col         (req_col),
        .req_row         (req_row),
        .req_has_col     (req_has_col),
        .req_has_row     (req_has_row),
        .req_confirm_sel (req_confirm_sel),
        .req_confirm     (req_confirm),
        .ddr_mode        (ddr_mode),
        .we_low_clks     (we_low_clks),
        .we_high_clks    (we_high_clks),
        .slot_byte       (slot_byte),
        .slot_is_cmd     (slot_is_cmd),
        .nxt_idx         (nxt_idx),
        .nxt_valid       (nxt_valid),
        .lat_cmd         (lat_cmd),
        .lat_col         (lat_col),
        .lat_row         (lat_row),
        .lat_has_col     (lat_has_col),
        .lat_has_row     (lat_has_row),
        .lat_confirm_sel (lat_confirm_sel),
        .lat_confirm     (lat_confirm),
        .lat_ddr         (lat_ddr),
        .cur_idx         (cur_idx),
        .bus_ce_n        (nand_ce_n),
        .bus_cle         (nand_cle),
        .bus_ale         (nand_ale),
        .bus_we_n        (nand_we_n),
        .bus_dq          (nand_dq),
        .done            (op_done)
    );

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic [7:0] nand_dq,
    input logic       op_done
);

    assert_ready_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> nand_ce_n);

    assert_take_then_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !nand_ce_n));

    assert_latch_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> ($stable(nand_dq) && $stable(nand_cle) && $stable(nand_ale)));

    assert_hold_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |=> $stable(nand_dq));

    assert_strobe_needs_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> !nand_ce_n);

    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_done_in_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (nand_we_n && !nand_cle && !nand_ale && !nand_ce_n));

    assert_done_then_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (req_ready && nand_ce_n && !op_done));

endmodule

bind nand_cmd_seq nand_cmd_seq_chk chk_i (.*);

// File: tb/nand_cmd_seq_tb_top.sv
module nand_cmd_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int COL_CYC    = 2;
    localparam int ROW_CYC    = 3;
    localparam int COL_BITS   = 15;
    localparam int ROW_BITS   = 21;
    localparam int TW         = 4;
    localparam int MAXN       = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [7:0] req_cmd = '0;
    logic [8*COL_CYC-1:0] req_col = '0;
    logic [8*ROW_CYC-1:0] req_row = '0;
    logic req_has_col = 1'b0;
    logic req_has_row = 1'b0;
    logic [1:0] req_confirm_sel = '0;
    logic [7:0] req_confirm = '0;
    logic ddr_mode = 1'b0;
    logic [TW-1:0] we_low_clks = TW'(1);
    logic [TW-1:0] we_high_clks = TW'(1);
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, op_done;
    logic [7:0] nand_dq;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_cmd_seq #(
        .COL_CYCLES (COL_CYC),
        .ROW_CYCLES (ROW_CYC),
        .COL_BITS   (COL_BITS),
        .ROW_BITS   (ROW_BITS),
        .TIME_W     (TW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_col(req_col), .req_row(req_row),
        .req_has_col(req_has_col), .req_has_row(req_has_row),
        .req_confirm_sel(req_confirm_sel), .req_confirm(req_confirm),
        .ddr_mode(ddr_mode), .we_low_clks(we_low_clks), .we_high_clks(we_high_clks),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_dq(nand_dq), .op_done(op_done)
    );

    int total = 0;
    int failed = 0;

    // expected and captured bus cycles
    int exp_byte [MAXN];
    int exp_cmd  [MAXN];
    int exp_n = 0;
    int cap_byte [MAXN];
    int cap_cmd  [MAXN];
    int cap_ale  [MAXN];
    int cap_low  [MAXN];
    int cap_high [MAXN];
    int cap_n = 0;
    int done_cnt = 0;
    int done_after = -1;
    int done_gap_ok = 1;
    int busy_ready = 0;
    int low_run = 0;
    int high_run = 0;
    bit in_high = 1'b0;
    logic prev_we = 1'b1;

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - failed, total);
    endtask

    // bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_ce_n && req_ready) busy_ready++;
            if (!nand_we_n) begin
                if (prev_we) low_run = 1;
                else low_run++;
                in_high = 1'b0;
            end else if (!prev_we) begin
                if (cap_n < MAXN) begin
                    cap_byte[cap_n] = int'(nand_dq);
                    cap_cmd[cap_n]  = int'(nand_cle);
                    cap_ale[cap_n]  = int'(nand_ale);
                    cap_low[cap_n]  = low_run;
                    cap_high[cap_n] = -1;
                    cap_n++;
                end
                high_run = 1;
                in_high = 1'b1;
            end else if (in_high) begin
                if (nand_cle || nand_ale) high_run++;
                else begin
                    in_high = 1'b0;
                    cap_high[cap_n-1] = high_run;
                end
            end
            if (op_done) begin
                done_cnt++;
                done_after = cap_n;
                if (nand_cle || nand_ale || !nand_we_n) done_gap_ok = 0;
            end
            prev_we = nand_we_n;
        end
    end

    task automatic clear_all();
        exp_n = 0;
        cap_n = 0;
        done_cnt = 0;
        done_after = -1;
        done_gap_ok = 1;
        busy_ready = 0;
    endtask

    task automatic push_exp(int b, int c);
        exp_byte[exp_n] = b;
        exp_cmd[exp_n]  = c;
        exp_n++;
    endtask

    // expected cycle list worked out from the requirements
    task automatic add_expect(int cmd, int col, int row, bit hc, bit hr,
                              int csel, int cbyte, bit ddr);
        int colm, rowm;
        colm = col & ((1 << COL_BITS) - 1);
        if (ddr) colm = colm & ~1;
        rowm = row & ((1 << ROW_BITS) - 1);
        push_exp(cmd, 1);
        if (hc) for (int k = 0; k < COL_CYC; k++) push_exp((colm >> (8*k)) & 8'hFF, 0);
        if (hr) for (int k = 0; k < ROW_CYC; k++) push_exp((rowm >> (8*k)) & 8'hFF, 0);
        if (csel == 1) push_exp(cbyte, 1);
        if (csel == 2) push_exp(8'h2D, 1);
        if (csel == 3) push_exp(8'h2E, 1);
    endtask

    task automatic drive_req(int cmd, int col, int row, bit hc, bit hr,
                             int csel, int cbyte, bit ddr, int lo, int hi);
        bit rdy;
        req_cmd = 8'(cmd);
        req_col = (8*COL_CYC)'(col);
        req_row = (8*ROW_CYC)'(row);
        req_has_col = hc;
        req_has_row = hr;
        req_confirm_sel = 2'(csel);
        req_confirm = 8'(cbyte);
        ddr_mode = ddr;
        we_low_clks = TW'(lo);
        we_high_clks = TW'(hi);
        req_valid = 1'b1;
        forever begin
            rdy = req_ready;
            @(negedge clk);
            if (rdy) break;
        end
        req_valid = 1'b0;
        req_cmd = 8'hA5;
        req_col = '1;
        req_row = '1;
    endtask

    task automatic wait_done(int k);
        while (done_cnt < k) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic compare(string tag, int lo, int hi);
        check(tag, "cycle count", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            check(tag, $sformatf("byte %0d", i), cap_byte[i], exp_byte[i]);
            check(tag, $sformatf("cle %0d", i), cap_cmd[i], exp_cmd[i]);
            check("R9", $sformatf("ale %0d", i), cap_ale[i], 1 - exp_cmd[i]);
            check("R8", $sformatf("low width %0d", i), cap_low[i], lo);
            check("R9", $sformatf("high then gap %0d", i), cap_high[i], hi);
        end
        check("R10", "one done pulse", done_cnt, 1);
        check("R10", "done after last cycle", done_after, exp_n);
        check("R10", "done in gap", done_gap_ok, 1);
        check("R10", "idle ready", int'(req_ready), 1);
        check("R10", "idle ce_n", int'(nand_ce_n), 1);
        check("R1", "ready while busy", busy_ready, 0);
    endtask

    task automatic run_op(string tag, int cmd, int col, int row, bit hc, bit hr,
                          int csel, int cbyte, bit ddr, int lo, int hi);
        clear_all();
        add_expect(cmd, col, row, hc, hr, csel, cbyte, ddr);
        drive_req(cmd, col, row, hc, hr, csel, cbyte, ddr, lo, hi);
        wait_done(1);
        compare(tag, (lo == 0) ? 1 : lo, (hi == 0) ? 1 : hi);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11", "ce_n", int'(nand_ce_n), 1);
        check("R11", "we_n", int'(nand_we_n), 1);
        check("R11", "cle", int'(nand_cle), 0);
        check("R11", "ale", int'(nand_ale), 0);
        check("R11", "done", int'(op_done), 0);
        check("R11", "ready", int'(req_ready), 1);
    endtask

    // R2 R3 R5 R7: full read sequence with masking of high address bits
    task automatic t_full_read();
        run_op("R3", 8'h00, 16'h1234, 24'hABCDEF, 1, 1, 1, 8'h30, 0, 2, 1);
        run_op("R5", 8'h00, 16'hFFFF, 24'hFFFFFF, 1, 1, 1, 8'h30, 0, 1, 2);
    endtask

    // R4: column bit 0 cleared only in DDR mode
    task automatic t_ddr();
        run_op("R4", 8'h05, 16'h80FF, 24'h0, 1, 0, 1, 8'hE0, 1, 1, 1);
        run_op("R4", 8'h05, 16'h0101, 24'h0, 1, 0, 1, 8'hE0, 0, 1, 1);
    endtask

    // R6: row-only erase and column-only request
    task automatic t_erase();
        run_op("R6", 8'h60, 16'hFFFF, 24'h123456, 0, 1, 1, 8'hD0, 0, 3, 2);
        run_op("R6", 8'h90, 16'h0000, 24'hFFFFFF, 1, 0, 0, 8'h00, 0, 1, 1);
    endtask

    // R7 R8: half-page confirm codes, zero phase lengths act as one clock
    task automatic t_half();
        run_op("R7", 8'h00, 16'h0000, 24'h000100, 1, 1, 2, 8'h77, 0, 0, 0);
        run_op("R7", 8'h00, 16'h2400, 24'h000100, 1, 1, 3, 8'h77, 0, 0, 0);
        run_op("R2", 8'hFF, 16'h0000, 24'h000000, 0, 0, 0, 8'h00, 0, 4, 3);
    endtask

    // R1: a second request waits until the first completes
    task automatic t_busy();
        clear_all();
        add_expect(8'h80, 16'h0010, 24'h000020, 1, 1, 0, 0, 0);
        add_expect(8'h85, 16'h0030, 24'h000000, 1, 0, 1, 8'h10, 0);
        drive_req(8'h80, 16'h0010, 24'h000020, 1, 1, 0, 0, 0, 2, 2);
        drive_req(8'h85, 16'h0030, 24'h000000, 1, 0, 1, 8'h10, 0, 2, 2);
        check("R1", "second waited for first done", done_cnt, 1);
        wait_done(2);
        check("R1", "total cycles", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            check("R1", $sformatf("byte %0d", i), cap_byte[i], exp_byte[i]);
        check("R1", "ready while busy", busy_ready, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL R10 watchdog expired: actual 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_read();
        t_ddr();
        t_erase();
        t_half();
        t_busy();
        summary();
        $finish;
    end

endmodule